// File: doc/BRIEF.md
# Pipelined Shift-and-Add Constant Multiplier Bank

This block multiplies one signed input sample by four fixed constants at the same time: 480, 512, 846 and 1020. It is meant to be the multiplier section of a transposed-form FIR filter, where each product feeds one tap's structural adder. It contains no general multiplier. The products are built from shifts and a small shared graph of adders and subtractors. The odd base values 1, 15, 47, 255 and 423 are computed once. Each even product is then a fixed left shift of one of them.

The graph has three register stages, one for each adder level. The stages sit between a registered input and a registered output, so a sample takes five clock edges to reach the outputs. Every node in a stage is either a registered adder or a pure delay. The 255 node is placed in the last stage, fed by a delayed copy of the input. The 15 needed for the 480 product is computed a second time in the last stage rather than being delayed. Both choices reduce the register count. A valid flag travels with the data. The datapath advances on every clock, whether or not the flag is set.

Top module: `cmul_pipe_bank`

## Requirements
- R1: `prod_480` equals 480 times the `in_smp` value that was sampled five rising edges earlier, as a signed two's-complement number.
- R2: `prod_512` equals 512 times the `in_smp` value that was sampled five rising edges earlier.
- R3: `prod_846` equals 846 times the `in_smp` value that was sampled five rising edges earlier.
- R4: `prod_1020` equals 1020 times the `in_smp` value that was sampled five rising edges earlier.
- R5: `out_vld` equals the `in_vld` value that was sampled five rising edges earlier.
- R6: While `rst_n` is low (active-low, asynchronous), `out_vld` and all four products read 0.
- R7: The outputs are `IN_W+10` bits wide and carry full precision. With the input at its most negative value (-2048 by default) or its most positive value (2047 by default), every product is exact and does not wrap.
- R8: The datapath does not depend on `in_vld`. A sample presented with `in_vld` low still appears five edges later as correct products, with `out_vld` low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Marks `in_smp` as a valid sample |
| in_smp | input | IN_W | Signed input sample |
| out_vld | output | 1 | Valid flag, delayed by five edges |
| prod_480 | output | IN_W+10 | Signed product x*480 |
| prod_512 | output | IN_W+10 | Signed product x*512 |
| prod_846 | output | IN_W+10 | Signed product x*846 |
| prod_1020 | output | IN_W+10 | Signed product x*1020 |

## Verification
In any one cycle, the first-stage adder that forms 15 and the duplicate 15 adder in the last stage are both working. Each of them works on a different sample. An error in how the duplicate is fed would therefore show up only when neighbouring samples differ. The bench provokes this by sending a new random or extreme sample on every clock, with no gaps. It then compares `prod_480` and the other products with a behavioural five-deep history of the inputs on every cycle. The same streaming also runs the valid flag through its own path at the same time as the data. Stretches with the flag low check that the products keep flowing while the flag is low.

// File: rtl/cmul_pkg.sv
package cmul_pkg;
    // Output growth over the input width: the largest constant is below 2**10.
    localparam int GROWTH   = 10;
    // Shift amounts used by the adder graph.
    localparam int SH_F15   = 4;  // 15  = 16*1 - 1
    localparam int SH_F47   = 5;  // 47  = 32*1 + 15
    localparam int SH_F255  = 8;  // 255 = 256*1 - 1
    localparam int SH_F423  = 3;  // 423 = 8*47 + 47
    // Wired shifts from odd fundamentals to the outputs.
    localparam int SH_O480  = 5;  // 480  = 15  << 5
    localparam int SH_O512  = 9;  // 512  = 1   << 9
    localparam int SH_O846  = 1;  // 846  = 423 << 1
    localparam int SH_O1020 = 2;  // 1020 = 255 << 2
    // Pipeline depth from input pin to output pin.
    localparam int LATENCY  = 5;
endpackage

// File: rtl/cmul_stage1.sv
module cmul_stage1
    import cmul_pkg::*;
#(
    parameter int W = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic signed [W-1:0] x_i,
    output logic                vld_o,
    output logic signed [W-1:0] n1_o,
    output logic signed [W-1:0] n15_o
);
    typedef struct packed {
        logic                vld;
        logic signed [W-1:0] n1;
        logic signed [W-1:0] n15;
    } s1_t;

    s1_t s1_d, s1_q;

    always_comb begin
        s1_d     = s1_q;
        s1_d.vld = vld_i;
        s1_d.n1  = x_i;
        s1_d.n15 = (x_i <<< SH_F15) - x_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s1_q <= '0;
        else        s1_q <= s1_d;
    end

    assign vld_o = s1_q.vld;
    assign n1_o  = s1_q.n1;
    assign n15_o = s1_q.n15;
endmodule

// File: rtl/cmul_stage2.sv
module cmul_stage2
    import cmul_pkg::*;
#(
    parameter int W = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic signed [W-1:0] n1_i,
    input  logic signed [W-1:0] n15_i,
    output logic                vld_o,
    output logic signed [W-1:0] n1_o,
    output logic signed [W-1:0] n47_o
);
    typedef struct packed {
        logic                vld;
        logic signed [W-1:0] n1;
        logic signed [W-1:0] n47;
    } s2_t;

    s2_t s2_d, s2_q;

    always_comb begin
        s2_d     = s2_q;
        s2_d.vld = vld_i;
        s2_d.n1  = n1_i;                       // pure delay for later use
        s2_d.n47 = (n1_i <<< SH_F47) + n15_i;  // registered adder
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s2_q <= '0;
        else        s2_q <= s2_d;
    end

    assign vld_o = s2_q.vld;
    assign n1_o  = s2_q.n1;
    assign n47_o = s2_q.n47;
endmodule

// File: rtl/cmul_stage3.sv
module cmul_stage3
    import cmul_pkg::*;
#(
    parameter int W = 22
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_i,
    input  logic signed [W-1:0] n1_i,
    input  logic signed [W-1:0] n47_i,
    output logic                vld_o,
    output logic signed [W-1:0] n1_o,
    output logic signed [W-1:0] n15_o,
    output logic signed [W-1:0] n255_o,
    output logic signed [W-1:0] n423_o
);
    typedef struct packed {
        logic                vld;
        logic signed [W-1:0] n1;
        logic signed [W-1:0] n15;
        logic signed [W-1:0] n255;
        logic signed [W-1:0] n423;
    } s3_t;

    s3_t s3_d, s3_q;

    always_comb begin
        s3_d      = s3_q;
        s3_d.vld  = vld_i;
        s3_d.n1   = n1_i;
        // Duplicate of the stage-1 adder; replaces a two-stage delay line.
        s3_d.n15  = (n1_i <<< SH_F15) - n1_i;
        // Scheduled late on purpose: only needs the delayed input.
        s3_d.n255 = (n1_i <<< SH_F255) - n1_i;
        s3_d.n423 = (n47_i <<< SH_F423) + n47_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s3_q <= '0;
        else        s3_q <= s3_d;
    end

    assign vld_o  = s3_q.vld;
    assign n1_o   = s3_q.n1;
    assign n15_o  = s3_q.n15;
    assign n255_o = s3_q.n255;
    assign n423_o = s3_q.n423;
endmodule

// File: rtl/cmul_pipe_bank.sv
module cmul_pipe_bank
    import cmul_pkg::*;
#(
    parameter int IN_W  = 12,
    parameter int OUT_W = IN_W + GROWTH
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_vld,
    input  logic signed [IN_W-1:0]  in_smp,
    output logic                    out_vld,
    output logic signed [OUT_W-1:0] prod_480,
    output logic signed [OUT_W-1:0] prod_512,
    output logic signed [OUT_W-1:0] prod_846,
    output logic signed [OUT_W-1:0] prod_1020
);
    localparam logic signed [OUT_W-1:0] K255 = OUT_W'(255);
    localparam logic signed [OUT_W-1:0] K423 = OUT_W'(423);

    // Input register
    typedef struct packed {
        logic                   vld;
        logic signed [IN_W-1:0] x;
    } in_t;

    in_t in_d, in_q;

    always_comb begin
        in_d     = in_q;
        in_d.vld = in_vld;
        in_d.x   = in_smp;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) in_q <= '0;
        else        in_q <= in_d;
    end

    logic signed [OUT_W-1:0] x_ext;
    assign x_ext = OUT_W'(in_q.x);

    // Adder graph stages
    logic                    s1_vld, s2_vld, s3_vld;
    logic signed [OUT_W-1:0] s1_n1, s1_n15;
    logic signed [OUT_W-1:0] s2_n1, s2_n47;
    logic signed [OUT_W-1:0] s3_n1, s3_n15, s3_n255, s3_n423;

    cmul_stage1 #(.W(OUT_W)) stage1_i (
        .clk(clk), .rst_n(rst_n),
        .vld_i(in_q.vld), .x_i(x_ext),
        .vld_o(s1_vld), .n1_o(s1_n1), .n15_o(s1_n15)
    );

    cmul_stage2 #(.W(OUT_W)) stage2_i (
        .clk(clk), .rst_n(rst_n),
        .vld_i(s1_vld), .n1_i(s1_n1), .n15_i(s1_n15),
        .vld_o(s2_vld), .n1_o(s2_n1), .n47_o(s2_n47)
    );

    cmul_stage3 #(.W(OUT_W)) stage3_i (
        .clk(clk), .rst_n(rst_n),
        .vld_i(s2_vld), .n1_i(s2_n1), .n47_i(s2_n47),
        .vld_o(s3_vld), .n1_o(s3_n1), .n15_o(s3_n15),
        .n255_o(s3_n255), .n423_o(s3_n423)
    );

    // Output register with wired shifts
    typedef struct packed {
        logic                    vld;
        logic signed [OUT_W-1:0] p480;
        logic signed [OUT_W-1:0] p512;
        logic signed [OUT_W-1:0] p846;
        logic signed [OUT_W-1:0] p1020;
    } out_t;

    out_t out_d, out_q;

    always_comb begin
        out_d       = out_q;
        out_d.vld   = s3_vld;
        out_d.p480  = s3_n15  <<< SH_O480;
        out_d.p512  = s3_n1   <<< SH_O512;
        out_d.p846  = s3_n423 <<< SH_O846;
        out_d.p1020 = s3_n255 <<< SH_O1020;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign out_vld   = out_q.vld;
    assign prod_480  = out_q.p480;
    assign prod_512  = out_q.p512;
    assign prod_846  = out_q.p846;
    assign prod_1020 = out_q.p1020;

    // Edges since reset, saturating; arms the history-based checks.
    logic [2:0] age_d, age_q;

    always_comb begin
        age_d = (age_q == 3'd7) ? age_q : age_q + 3'd1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) age_q <= '0;
        else        age_q <= age_d;
    end

    // R1: the duplicated 15 adder agrees with the stage-1 adder on the same sample
    a_r1_dup_f15_agrees: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd2) |-> (s3_n15 == $past(s1_n15, 2)));

    // R2: the carried unit value reaches stage 3 unchanged
    a_r2_unit_carried: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd2) |-> (s3_n1 == $past(s1_n1, 2)));

    // R3: node 423 is the registered input times 423
    a_r3_node423: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd3) |-> (s3_n423 == $past(x_ext, 3) * K423));

    // R4: node 255 is the registered input times 255
    a_r4_node255: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd3) |-> (s3_n255 == $past(x_ext, 3) * K255));

    // R5: valid emerges five edges after the input pin
    a_r5_valid_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q >= 3'd5) |-> (out_vld == $past(in_vld, 5)));
endmodule

// File: tb/cmul_pipe_bank_tb_top.sv
module cmul_pipe_bank_tb_top;
    localparam int IN_W  = 12;
    localparam int OUT_W = IN_W + 10;
    localparam int DEPTH = 5;
    localparam int XMIN  = -(1 << (IN_W - 1));
    localparam int XMAX  = (1 << (IN_W - 1)) - 1;

    logic                    clk = 1'b0;
    logic                    rst_n = 1'b0;
    logic                    in_vld = 1'b0;
    logic signed [IN_W-1:0]  in_smp = '0;
    logic                    out_vld;
    logic signed [OUT_W-1:0] prod_480, prod_512, prod_846, prod_1020;

    int n_checks = 0;
    int n_fail   = 0;
    int hx [DEPTH];
    bit hv [DEPTH];

    always #10 clk = ~clk;

    cmul_pipe_bank #(.IN_W(IN_W)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .in_vld(in_vld), .in_smp(in_smp),
        .out_vld(out_vld),
        .prod_480(prod_480), .prod_512(prod_512),
        .prod_846(prod_846), .prod_1020(prod_1020)
    );

    // Behavioural history of what was presented at each edge
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin hx[i] = 0; hv[i] = 0; end
        end else begin
            for (int i = DEPTH - 1; i > 0; i--) begin hx[i] = hx[i-1]; hv[i] = hv[i-1]; end
            hx[0] = int'(in_smp);
            hv[0] = in_vld;
        end
    end

    task automatic chk(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    // Compare outputs with the five-deep history; called away from the rising edge
    task automatic compare_now();
        int x;
        x = hx[DEPTH-1];
        chk("R1 prod_480",  int'(prod_480),  x * 480);
        chk("R2 prod_512",  int'(prod_512),  x * 512);
        chk("R3 prod_846",  int'(prod_846),  x * 846);
        chk("R4 prod_1020", int'(prod_1020), x * 1020);
        chk("R5 out_vld",   int'(out_vld),   int'(hv[DEPTH-1]));
        if (x == XMIN || x == XMAX) begin
            chk("R7 extreme prod_1020", int'(prod_1020), x * 1020);
            chk("R7 extreme prod_846",  int'(prod_846),  x * 846);
        end
        if (!hv[DEPTH-1] && x != 0) begin
            chk("R8 data flows with valid low", int'(prod_480), x * 480);
        end
    endtask

    task automatic step(bit v, int x);
        @(negedge clk);
        compare_now();
        in_vld = v;
        in_smp = IN_W'(x);
    endtask

    initial begin
        #(20 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Reset phase, with non-zero stimulus on the inputs
        in_vld = 1'b1;
        in_smp = IN_W'(77);
        repeat (4) @(negedge clk);
        chk("R6 reset out_vld",   int'(out_vld),   0);
        chk("R6 reset prod_480",  int'(prod_480),  0);
        chk("R6 reset prod_512",  int'(prod_512),  0);
        chk("R6 reset prod_846",  int'(prod_846),  0);
        chk("R6 reset prod_1020", int'(prod_1020), 0);
        in_vld = 1'b0;
        in_smp = '0;
        rst_n  = 1'b1;

        // Extremes back to back (R7)
        step(1'b1, XMIN);
        step(1'b1, XMAX);
        step(1'b1, 0);
        step(1'b1, -1);
        step(1'b1, 1);
        step(1'b1, XMIN);
        step(1'b1, XMIN);
        step(1'b1, XMAX);

        // Continuous stream of random samples (R1-R5)
        for (int i = 0; i < 400; i++)
            step(1'b1, int'($urandom_range(0, 2 * XMAX + 1)) + XMIN);

        // Valid toggling randomly, including low-valid data (R5, R8)
        for (int i = 0; i < 400; i++)
            step(1'($urandom_range(0, 1)), int'($urandom_range(0, 2 * XMAX + 1)) + XMIN);

        // Block of valid-low samples with non-zero data (R8)
        for (int i = 0; i < 12; i++)
            step(1'b0, (i % 2 == 0) ? XMAX - i : XMIN + i);

        // Flush
        for (int i = 0; i < DEPTH + 2; i++)
            step(1'b0, 0);

        finish_run();
    end
endmodule